// File: doc/BRIEF.md
# DMA Block-Transfer Channel

This block is one DMA channel that copies memory in whole blocks. Each accepted request moves `blk_size` word units. Every unit is a read bus cycle at the source address, then a write bus cycle to the destination address carrying the word just read. When the block is done the channel drops bus ownership, so another master gets at least one bus cycle, and then it waits for the next request. Once the programmed number of blocks has been moved, the channel turns itself off and must be enabled again by software.

Read and write cycles each last their own configured number of states. This lets a fast source be paired with a slower destination. A request arrives either as a falling edge or as a low level on `req_n`. A non-maskable interrupt input is watched, but it never cuts a block short. Its notification is held back until the channel is off the bus. Configuration writes are accepted only while no block is in flight.

Top module: `dma_block_channel`

## Requirements
- R1: One accepted request moves exactly `blk_size` units. After that, `bus_own` falls and stays low until another request is accepted.
- R2: Between two blocks, `bus_own` is low for at least one clock cycle.
- R3: Each unit is a read at the current source address, then a write to the current destination address. The write data equals the word read. `bus_rd` and `bus_wr` are never high together.
- R4: In the block that brings the block count to zero, exactly one cycle follows the last write in which `bus_own` is high and both strobes are low. Any other block releases the bus straight after its last write.
- R5: A read stays high for `src_states` cycles and a write for `dst_states` cycles. A value of 0 is treated as 1. The address is stable throughout.
- R6: The source address steps by +2 after each unit when `src_inc` is set, and otherwise stays fixed. The destination address does the same under `dst_inc`. Both addresses carry over from one block to the next.
- R7: With `edge_mode`=1, a falling edge on `req_n` starts a block. With `edge_mode`=0, `req_n` held low starts blocks one after another. `req_n` is registered before it is used.
- R8: Falling edges that arrive while a block owns the bus are discarded. An edge detected during the release cycle is remembered and starts the next block without another edge.
- R9: `xfer_end` is high throughout every bus-owning cycle of the final block, including its dead cycle. It is low at all other times.
- R10: When the final block ends, `chan_en` clears and `done` pulses for one cycle. Later requests start nothing until the enable bit is written again.
- R11: A rising `nmi` is latched. `nmi_fwd` pulses for one cycle, and only while `bus_own` is low. An `nmi` that arrives during a block is reported after that block.
- R12: Register map, selected by `cfg_sel`: 0 = source address, 1 = destination address, 2 = block size, 3 = block count, 4 = control. The control bits are: [0] enable, [1] `edge_mode`, [2] `src_inc`, [3] `dst_inc`, [7:4] `src_states`, [11:8] `dst_states`. Writes made while `bus_own` is high are ignored. `chan_en` shows the enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | DW | Register write data |
| req_n | input | 1 | Active-low transfer request |
| nmi | input | 1 | Non-maskable interrupt, observed only |
| bus_own | output | 1 | Channel holds the bus |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, captured on the last read state |
| xfer_end | output | 1 | Final-block indicator |
| done | output | 1 | One-cycle pulse when the count is exhausted |
| chan_en | output | 1 | Channel enable bit |
| nmi_fwd | output | 1 | Deferred interrupt notification |

## Verification
The state that matters most is the unit counter, the block counter and the final-block flag. A wrong unit count changes how many read/write pairs appear before `bus_own` falls, so it is visible within one block. A wrong block count or final-block flag moves the dead cycle, `xfer_end` and `done` to a different block, and shows up when the sequence should have ended. A pending-request latch with the wrong value shows up as a block that is missing or one that was never requested, within a couple of cycles after the release. A corrupted address register shows on `bus_addr` at the very next strobe.

// File: rtl/dma_block_channel.sv
module dma_block_channel #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 8,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          req_n,
  input  logic          nmi,
  output logic          bus_own,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic          xfer_end,
  output logic          done,
  output logic          chan_en,
  output logic          nmi_fwd
);
  localparam logic [AW-1:0] STEP = AW'(2);
  localparam logic [CW-1:0] C1 = CW'(1);
  localparam logic [SW-1:0] W1 = SW'(1);

  typedef enum logic [2:0] {S_IDLE, S_READ, S_WRITE, S_DEAD, S_REL} st_t;
  st_t state;

  logic [AW-1:0] src_a, dst_a;
  logic [CW-1:0] blk_size, blk_cnt, unit_cnt;
  logic [SW-1:0] src_st, dst_st, wcnt;
  logic [DW-1:0] data_q;
  logic en, edge_md, src_inc, dst_inc, last_blk, pend;
  logic r1, r2, n1, nmi_lat, done_q;

  logic in_blk, req_fall, trig, start, rd_last, wr_last, cfg_ok, ctl_wr;

  assign in_blk   = (state == S_READ) || (state == S_WRITE) || (state == S_DEAD);
  assign req_fall = r2 & ~r1;
  assign trig     = edge_md ? pend : ~r1;
  assign start    = (state == S_IDLE) && en && trig && (blk_cnt != '0) && (blk_size != '0);
  assign rd_last  = wcnt >= src_st;
  assign wr_last  = wcnt >= dst_st;
  assign cfg_ok   = cfg_we && !in_blk;
  assign ctl_wr   = cfg_ok && (cfg_sel == 3'd4);

  assign bus_own   = in_blk;
  assign bus_rd    = state == S_READ;
  assign bus_wr    = state == S_WRITE;
  assign bus_addr  = (state == S_WRITE) ? dst_a : src_a;
  assign bus_wdata = data_q;
  assign xfer_end  = in_blk && last_blk;
  assign done      = done_q;
  assign chan_en   = en;
  assign nmi_fwd   = nmi_lat && !in_blk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      src_a <= '0; dst_a <= '0;
      blk_size <= '0; blk_cnt <= '0; unit_cnt <= '0;
      src_st <= '0; dst_st <= '0; wcnt <= W1;
      data_q <= '0;
      en <= 1'b0; edge_md <= 1'b0; src_inc <= 1'b0; dst_inc <= 1'b0;
      last_blk <= 1'b0; pend <= 1'b0;
      r1 <= 1'b1; r2 <= 1'b1; n1 <= 1'b0; nmi_lat <= 1'b0; done_q <= 1'b0;
    end else begin
      r1 <= req_n;
      r2 <= r1;
      n1 <= nmi;
      done_q <= 1'b0;

      if (nmi && !n1) nmi_lat <= 1'b1;
      else if (nmi_fwd) nmi_lat <= 1'b0;

      if (cfg_ok) begin
        case (cfg_sel)
          3'd0: src_a <= cfg_wdata[AW-1:0];
          3'd1: dst_a <= cfg_wdata[AW-1:0];
          3'd2: blk_size <= cfg_wdata[CW-1:0];
          3'd3: blk_cnt <= cfg_wdata[CW-1:0];
          3'd4: begin
            en      <= cfg_wdata[0];
            edge_md <= cfg_wdata[1];
            src_inc <= cfg_wdata[2];
            dst_inc <= cfg_wdata[3];
            src_st  <= cfg_wdata[4 +: SW];
            dst_st  <= cfg_wdata[4+SW +: SW];
          end
          default: ;
        endcase
      end

      if (start || ctl_wr) pend <= 1'b0;
      else if (req_fall && en && !in_blk) pend <= 1'b1;

      case (state)
        S_IDLE: if (start) begin
          state    <= S_READ;
          unit_cnt <= blk_size;
          wcnt     <= W1;
          last_blk <= blk_cnt == C1;
        end
        S_READ: if (rd_last) begin
          data_q <= bus_rdata;
          wcnt   <= W1;
          state  <= S_WRITE;
        end else wcnt <= wcnt + W1;
        S_WRITE: if (wr_last) begin
          wcnt <= W1;
          if (src_inc) src_a <= src_a + STEP;
          if (dst_inc) dst_a <= dst_a + STEP;
          unit_cnt <= unit_cnt - C1;
          if (unit_cnt == C1) begin
            blk_cnt <= blk_cnt - C1;
            state   <= last_blk ? S_DEAD : S_REL;
          end else state <= S_READ;
        end else wcnt <= wcnt + W1;
        S_DEAD: begin
          en     <= 1'b0;
          done_q <= 1'b1;
          state  <= S_REL;
        end
        S_REL: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_block_channel_chk.sv
module dma_block_channel_chk #(parameter int AW = 16) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_own,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic          xfer_end,
  input logic          done,
  input logic          chan_en,
  input logic          nmi_fwd
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(bus_rd && bus_wr)); // R3
  AST_STROBE_OWNED: assert property (@(posedge clk) disable iff (!rst_n) (bus_rd || bus_wr) |-> bus_own); // R1
  AST_RELEASE_GAP: assert property (@(posedge clk) disable iff (!rst_n) $fell(bus_own) |=> !bus_own); // R2
  AST_DEAD_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!bus_own && $past(bus_own) && !$past(bus_rd) && !$past(bus_wr))); // R4
  AST_READ_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && $past(bus_rd)) |-> $stable(bus_addr)); // R5
  AST_WRITE_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && $past(bus_wr)) |-> $stable(bus_addr)); // R5
  AST_END_OWNED: assert property (@(posedge clk) disable iff (!rst_n) xfer_end |-> bus_own); // R9
  AST_DONE_DISABLES: assert property (@(posedge clk) disable iff (!rst_n) done |-> !chan_en); // R10
  AST_NMI_DEFERRED: assert property (@(posedge clk) disable iff (!rst_n) nmi_fwd |-> !bus_own); // R11
endmodule

bind dma_block_channel dma_block_channel_chk #(.AW(AW)) u_chk (.*);

// File: tb/dma_block_channel_test.sv
module dma_block_channel_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, req_n = 1'b1, nmi = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic bus_own, bus_rd, bus_wr, xfer_end, done, chan_en, nmi_fwd;
  logic [15:0] bus_addr, bus_wdata, bus_rdata;

  always #2.5 clk = ~clk;
  assign bus_rdata = bus_addr ^ 16'h5A5A;

  dma_block_channel uut (.*);

  typedef struct packed {
    logic [1:0]  kind;
    logic [15:0] addr;
    logic [15:0] data;
    logic [7:0]  len;
  } item_t;
  item_t expq[$];

  int vectors = 0, miscompares = 0;
  int blk_starts = 0, done_cnt = 0, nmi_seen = 0;

  task automatic check(input bit ok, input string tag, input string what, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic cmp(input item_t got);
    item_t e;
    if (expq.size() == 0) begin
      check(0, "R1", "unexpected bus activity kind", got.kind, 3);
      return;
    end
    e = expq.pop_front();
    check(got.kind == e.kind, "R1", "item kind", got.kind, e.kind);
    if (e.kind == 2'd2) begin
      check(got.data[2] == e.data[2], "R4", "dead cycle", got.data[2], e.data[2]);
      check(got.data[1:0] == e.data[1:0], "R9", "xfer_end any/all", got.data[1:0], e.data[1:0]);
    end else begin
      check(got.addr == e.addr, "R6", "address", got.addr, e.addr);
      check(got.len == e.len, "R5", "strobe length", got.len, e.len);
      if (e.kind == 2'd1) check(got.data == e.data, "R3", "write data", got.data, e.data);
    end
  endtask

  logic prd = 0, pwr = 0, pown = 0, xe_any, xe_all;
  int rlen, wlen, dead, gap = 0;
  logic [15:0] raddr, waddr, wdat;

  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_rd) begin
        if (!prd) begin raddr = bus_addr; rlen = 0; end
        rlen++;
      end else if (prd) cmp(item_t'{2'd0, raddr, 16'd0, 8'(rlen)});
      if (bus_wr) begin
        if (!pwr) begin waddr = bus_addr; wdat = bus_wdata; wlen = 0; end
        wlen++;
      end else if (pwr) cmp(item_t'{2'd1, waddr, wdat, 8'(wlen)});
      if (bus_rd && bus_wr) check(0, "R3", "both strobes", 1, 0);
      if (bus_own && !pown) begin
        if (blk_starts > 0) check(gap >= 1, "R2", "release gap", gap, 1);
        blk_starts++;
        dead = 0; xe_any = 0; xe_all = 1;
      end
      if (bus_own) begin
        if (!bus_rd && !bus_wr) dead++;
        xe_any |= xfer_end;
        xe_all &= xfer_end;
        gap = 0;
      end else begin
        gap++;
        if (pown) cmp(item_t'{2'd2, 16'd0, 16'(dead * 4 + int'(xe_any) * 2 + int'(xe_all)), 8'd0});
      end
      if (xfer_end && !bus_own) check(0, "R9", "xfer_end while released", 1, 0);
      if (nmi_fwd) begin
        nmi_seen++;
        if (bus_own) check(0, "R11", "nmi_fwd during block", 1, 0);
      end
      if (done) done_cnt++;
      prd = bus_rd; pwr = bus_wr; pown = bus_own;
    end
  end

  task automatic cfg(input logic [2:0] sel, input logic [15:0] val);
    @(negedge clk); cfg_we = 1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk); cfg_we = 0;
  endtask

  function automatic logic [15:0] ctl(bit e, bit ed, bit si, bit di, int ss, int ds);
    return {4'b0, 4'(ds), 4'(ss), di, si, ed, e};
  endfunction

  task automatic setup(input logic [15:0] s, d, input int size, cnt, input logic [15:0] c);
    cfg(3'd0, s); cfg(3'd1, d); cfg(3'd2, 16'(size)); cfg(3'd3, 16'(cnt)); cfg(3'd4, c);
  endtask

  task automatic exp_block(inout logic [15:0] s, d, input int size, bit si, di, int ss, ds, bit last);
    for (int u = 0; u < size; u++) begin
      expq.push_back(item_t'{2'd0, s, 16'd0, 8'(ss == 0 ? 1 : ss)});
      expq.push_back(item_t'{2'd1, d, s ^ 16'h5A5A, 8'(ds == 0 ? 1 : ds)});
      if (si) s += 16'd2;
      if (di) d += 16'd2;
    end
    expq.push_back(item_t'{2'd2, 16'd0, last ? 16'd7 : 16'd0, 8'd0});
  endtask

  task automatic pulse_req();
    @(negedge clk); req_n = 0;
    repeat (2) @(negedge clk);
    req_n = 1;
  endtask

  task automatic wait_block_end();
    int n = 0;
    while (!bus_own && n < 200) begin @(negedge clk); n++; end
    while (bus_own && n < 4000) begin @(negedge clk); n++; end
  endtask

  task automatic drained(input string tag);
    repeat (2) @(negedge clk);
    check(expq.size() == 0, tag, "expected items left", expq.size(), 0);
    expq.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [15:0] s, d;
    int b0, n0, d0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check({bus_own, bus_rd, bus_wr, xfer_end, done, chan_en, nmi_fwd} == 7'b0, "R1", "reset outputs",
          {bus_own, bus_rd, bus_wr, xfer_end, done, chan_en, nmi_fwd}, 0);

    // R6 R7 R10 R12: two edge-triggered blocks, both addresses incrementing
    s = 16'h1000; d = 16'h2000;
    setup(s, d, 3, 2, ctl(1, 1, 1, 1, 1, 2));
    check(chan_en == 1, "R12", "chan_en after enable write", chan_en, 1);
    exp_block(s, d, 3, 1, 1, 1, 2, 0);
    pulse_req(); wait_block_end(); drained("R1");
    check(done_cnt == 0, "R10", "no done after first block", done_cnt, 0);
    exp_block(s, d, 3, 1, 1, 1, 2, 1);
    pulse_req(); wait_block_end(); drained("R1");
    check(done_cnt == 1, "R10", "done pulses", done_cnt, 1);
    check(chan_en == 0, "R10", "chan_en cleared", chan_en, 0);
    b0 = blk_starts;
    pulse_req(); repeat (30) @(negedge clk);
    check(blk_starts == b0, "R10", "request after count exhausted", blk_starts, b0);

    // R7 level mode, fixed destination, unequal access lengths, state 0 as 1
    s = 16'h3000; d = 16'h4000; b0 = blk_starts;
    setup(s, d, 2, 2, ctl(1, 0, 1, 0, 3, 0));
    exp_block(s, d, 2, 1, 0, 3, 0, 0);
    exp_block(s, d, 2, 1, 0, 3, 0, 1);
    @(negedge clk); req_n = 0;
    wait_block_end(); wait_block_end();
    repeat (20) @(negedge clk);
    req_n = 1;
    drained("R7");
    check(blk_starts == b0 + 2, "R7", "level-mode block count", blk_starts, b0 + 2);

    // R8 edge inside a block is discarded
    s = 16'h5000; d = 16'h6000;
    setup(s, d, 4, 2, ctl(1, 1, 1, 1, 2, 2));
    exp_block(s, d, 4, 1, 1, 2, 2, 0);
    pulse_req();
    while (!bus_wr) @(negedge clk);
    pulse_req();
    wait_block_end(); b0 = blk_starts;
    repeat (30) @(negedge clk);
    check(blk_starts == b0, "R8", "edge during block started a block", blk_starts, b0);
    drained("R8");
    exp_block(s, d, 4, 1, 1, 2, 2, 1);
    pulse_req(); wait_block_end(); drained("R1");

    // R8 edge in the release cycle is latched
    s = 16'h7000; d = 16'h7100;
    setup(s, d, 2, 2, ctl(1, 1, 1, 1, 1, 1));
    exp_block(s, d, 2, 1, 1, 1, 1, 0);
    exp_block(s, d, 2, 1, 1, 1, 1, 1);
    pulse_req();
    begin
      int w = 0;
      while (w < 2) begin @(negedge clk); if (bus_wr) w++; end
    end
    req_n = 0;
    wait_block_end(); b0 = blk_starts;
    wait_block_end();
    req_n = 1;
    check(blk_starts == b0 + 1, "R8", "latched release edge served", blk_starts, b0 + 1);
    drained("R8");

    // R11 nmi during a block is deferred
    s = 16'h8000; d = 16'h8100; n0 = nmi_seen; d0 = done_cnt;
    setup(s, d, 3, 1, ctl(1, 1, 1, 1, 1, 1));
    exp_block(s, d, 3, 1, 1, 1, 1, 1);
    pulse_req();
    while (!bus_own) @(negedge clk);
    nmi = 1; @(negedge clk); nmi = 0;
    repeat (2) @(negedge clk);
    check(nmi_seen == n0, "R11", "nmi forwarded during block", nmi_seen, n0);
    wait_block_end(); repeat (4) @(negedge clk);
    check(nmi_seen == n0 + 1, "R11", "nmi forwarded after block", nmi_seen, n0 + 1);
    check(done_cnt == d0 + 1, "R10", "single-block done", done_cnt, d0 + 1);
    drained("R1");

    // R11 nmi while idle is forwarded promptly
    n0 = nmi_seen;
    @(negedge clk); nmi = 1; @(negedge clk); nmi = 0;
    repeat (3) @(negedge clk);
    check(nmi_seen == n0 + 1, "R11", "idle nmi forwarded", nmi_seen, n0 + 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule